// File: doc/BRIEF.md
# Multi-mode output compare channel

This block is one output-compare channel. It watches the count of one of two external free-running timers and drives a single output pin. A 3-bit mode value selects the pin behaviour. Four modes act on a single compare value: off, set on match, clear on match, and toggle on match. Two pulse modes use a rise value and a fall value. Two PWM modes take their period from the timer rollover, and one of them also obeys an external fault input. Software writes the control fields and the two compare values through write strobes. A status flag reports a fault trip. Software cannot clear this flag. The flag is cleared only when software writes the control fields again.

A compare match is the cycle in which the selected count becomes equal to a compare value. The pin reacts on the clock edge that ends that cycle. So the new pin level appears in the cycle after the matching count. Writing the control fields restarts the channel in the new mode at that same write edge.

Top module: `ocmp_channel`

## Requirements
- R1: After reset the pin and the fault flag are low and the mode is off (code 000). In mode 000 the pin stays low whatever the count does.
- R2: A control write with mode 001 drives the pin low. The pin goes high in the cycle after the selected count first equals the primary compare value, and it stays high.
- R3: A control write with mode 010 drives the pin high. The pin goes low in the cycle after the count equals the primary compare value.
- R4: In mode 011 the pin starts low after the control write and inverts after every primary compare match.
- R5: In mode 100 the pin starts low. The pin rises after a primary match. It falls after a later secondary match. No further pulse occurs until the next control write.
- R6: In mode 101 the pin rises after each primary match while it is low, and it falls after each secondary match while it is high. This repeats every timer period.
- R7: In mode 110 the duty value is loaded from the secondary register at each rollover strobe. In the timer cycles from count 0 through count duty, the pin is high when duty is nonzero. It is low in the other cycles, and it is low for the whole period when duty is zero. The fault input has no effect in this mode.
- R8: In mode 111, if the fault input is sampled high, the pin is low and the fault flag is set from the next cycle on. The flag does not set in any other mode.
- R9: Once the fault flag is set, it and the low pin persist through rollovers and compare-register writes. Only a control write clears the flag. PWM output then resumes at the next rollover.
- R10: The timer select bit picks the count and the rollover strobe: 0 selects timer 0 and 1 selects timer 1.
- R11: While the idle-stop bit is 1 and the idle input is high, compare matches and rollovers leave the pin unchanged. While the idle-stop bit is 0, idle has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ctl_wr | input | 1 | Write strobe for the mode, timer select and idle-stop fields; restarts the channel |
| ctl_mode | input | 3 | Mode code to write |
| ctl_tsel | input | 1 | Timer select to write (0 = timer 0, 1 = timer 1) |
| ctl_idle_stop | input | 1 | Idle-stop bit to write |
| pri_wr | input | 1 | Write strobe for the primary compare value |
| pri_wdata | input | CNT_W | Primary compare value |
| sec_wr | input | 1 | Write strobe for the secondary compare value |
| sec_wdata | input | CNT_W | Secondary compare value (pulse fall point or PWM duty) |
| tmr0_cnt | input | CNT_W | Count of timer 0 |
| tmr0_wrap | input | 1 | Rollover strobe of timer 0 |
| tmr1_cnt | input | CNT_W | Count of timer 1 |
| tmr1_wrap | input | 1 | Rollover strobe of timer 1 |
| idle | input | 1 | Idle-state indication |
| fault | input | 1 | External fault input, active high |
| oc_out | output | 1 | Compare output pin |
| fault_flag | output | 1 | Fault status, read-only |

## Verification
The bench builds the block with its default 16-bit count width. It drives timer 0 with a period of 16 counts and timer 1 with a period of 10 counts, with each rollover strobe high on the last count. These short periods bring every primary compare value of a period within reach of the set and clear modes. They also allow a full sweep of PWM duty values, including zero, full period and beyond period. The pulse modes use rise-before-fall, fall-before-rise and equal compare pairs. The fault, idle-stop and timer-select cases each run over whole timer periods.

// File: rtl/ocmp_pkg.sv
package ocmp_pkg;
  typedef enum logic [2:0] {
    OM_OFF  = 3'd0,
    OM_SET  = 3'd1,
    OM_CLR  = 3'd2,
    OM_TGL  = 3'd3,
    OM_ONE  = 3'd4,
    OM_RPT  = 3'd5,
    OM_PWM  = 3'd6,
    OM_PWMF = 3'd7
  } oc_mode_e;

  localparam int NUM_REF  = 3;
  localparam int REF_PRI  = 0;
  localparam int REF_SEC  = 1;
  localparam int REF_DUTY = 2;
endpackage

// File: rtl/ocmp_regs.sv
module ocmp_regs
  import ocmp_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_wr,
  input  logic [2:0]       ctl_mode,
  input  logic             ctl_tsel,
  input  logic             ctl_idle_stop,
  input  logic             pri_wr,
  input  logic [CNT_W-1:0] pri_wdata,
  input  logic             sec_wr,
  input  logic [CNT_W-1:0] sec_wdata,
  output oc_mode_e         mode_q,
  output logic             tsel_q,
  output logic             idle_stop_q,
  output logic [CNT_W-1:0] pri_q,
  output logic [CNT_W-1:0] sec_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q      <= OM_OFF;
      tsel_q      <= 1'b0;
      idle_stop_q <= 1'b0;
    end else if (ctl_wr) begin
      mode_q      <= oc_mode_e'(ctl_mode);
      tsel_q      <= ctl_tsel;
      idle_stop_q <= ctl_idle_stop;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pri_q <= '0;
    end else if (pri_wr) begin
      pri_q <= pri_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sec_q <= '0;
    end else if (sec_wr) begin
      sec_q <= sec_wdata;
    end
  end
endmodule

// File: rtl/ocmp_match.sv
module ocmp_match
  import ocmp_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            tsel,
  input  logic [CNT_W-1:0]                cnt0,
  input  logic                            wrap0,
  input  logic [CNT_W-1:0]                cnt1,
  input  logic                            wrap1,
  input  logic [NUM_REF-1:0][CNT_W-1:0]   refs,
  output logic [NUM_REF-1:0]              ev,
  output logic                            roll
);
  logic [CNT_W-1:0]   cnt_sel;
  logic [NUM_REF-1:0] eq_now;
  logic [NUM_REF-1:0] eq_prev_q;
  logic [NUM_REF-1:0] eq_prev_d;

  always_comb begin
    cnt_sel = tsel ? cnt1 : cnt0;
    roll    = tsel ? wrap1 : wrap0;
  end

  for (genvar g = 0; g < NUM_REF; g++) begin : g_cmp
    assign eq_now[g]    = (cnt_sel == refs[g]);
    assign ev[g]        = eq_now[g] & ~eq_prev_q[g];
    assign eq_prev_d[g] = eq_now[g];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      eq_prev_q <= '0;
    end else begin
      eq_prev_q <= eq_prev_d;
    end
  end
endmodule

// File: rtl/ocmp_engine.sv
module ocmp_engine
  import ocmp_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  oc_mode_e         mode,
  input  logic             run,
  input  logic             init,
  input  oc_mode_e         init_mode,
  input  logic             ev_pri,
  input  logic             ev_sec,
  input  logic             ev_duty,
  input  logic             roll,
  input  logic             fault,
  input  logic [CNT_W-1:0] sec_val,
  output logic             pin_q,
  output logic             flag_q,
  output logic [CNT_W-1:0] duty_q
);
  logic             pin_d;
  logic             flag_d;
  logic             armed_q;
  logic             armed_d;
  logic [CNT_W-1:0] duty_d;

  always_comb begin
    pin_d   = pin_q;
    flag_d  = flag_q;
    armed_d = armed_q;
    duty_d  = duty_q;
    if (init) begin
      pin_d   = (init_mode == OM_CLR);
      flag_d  = 1'b0;
      armed_d = 1'b1;
    end else if (mode == OM_PWMF && (fault || flag_q)) begin
      pin_d  = 1'b0;
      flag_d = 1'b1;
    end else if (run) begin
      unique case (mode)
        OM_OFF: pin_d = 1'b0;
        OM_SET: if (ev_pri) pin_d = 1'b1;
        OM_CLR: if (ev_pri) pin_d = 1'b0;
        OM_TGL: if (ev_pri) pin_d = ~pin_q;
        OM_ONE, OM_RPT: begin
          if (pin_q && ev_sec) begin
            pin_d = 1'b0;
            if (mode == OM_ONE) armed_d = 1'b0;
          end else if (!pin_q && ev_pri && armed_q) begin
            pin_d = 1'b1;
          end
        end
        OM_PWM, OM_PWMF: begin
          if (roll) begin
            duty_d = sec_val;
            pin_d  = (sec_val != '0);
          end else if (ev_duty) begin
            pin_d = 1'b0;
          end
        end
        default: pin_d = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_q   <= 1'b0;
      flag_q  <= 1'b0;
      armed_q <= 1'b0;
      duty_q  <= '0;
    end else begin
      pin_q   <= pin_d;
      flag_q  <= flag_d;
      armed_q <= armed_d;
      duty_q  <= duty_d;
    end
  end
endmodule

// File: rtl/ocmp_channel.sv
module ocmp_channel
  import ocmp_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_wr,
  input  logic [2:0]       ctl_mode,
  input  logic             ctl_tsel,
  input  logic             ctl_idle_stop,
  input  logic             pri_wr,
  input  logic [CNT_W-1:0] pri_wdata,
  input  logic             sec_wr,
  input  logic [CNT_W-1:0] sec_wdata,
  input  logic [CNT_W-1:0] tmr0_cnt,
  input  logic             tmr0_wrap,
  input  logic [CNT_W-1:0] tmr1_cnt,
  input  logic             tmr1_wrap,
  input  logic             idle,
  input  logic             fault,
  output logic             oc_out,
  output logic             fault_flag
);
  logic [1:0]                     rst_sync_q;
  logic                           rst_int_n;
  oc_mode_e                       mode_q;
  logic                           tsel_q;
  logic                           idle_stop_q;
  logic [CNT_W-1:0]               pri_q;
  logic [CNT_W-1:0]               sec_q;
  logic [CNT_W-1:0]               duty_q;
  logic [NUM_REF-1:0][CNT_W-1:0]  refs;
  logic [NUM_REF-1:0]             ev;
  logic                           roll;
  logic                           run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_int_n = rst_sync_q[1];

  ocmp_regs #(.CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_int_n),
    .ctl_wr(ctl_wr), .ctl_mode(ctl_mode), .ctl_tsel(ctl_tsel),
    .ctl_idle_stop(ctl_idle_stop),
    .pri_wr(pri_wr), .pri_wdata(pri_wdata),
    .sec_wr(sec_wr), .sec_wdata(sec_wdata),
    .mode_q(mode_q), .tsel_q(tsel_q), .idle_stop_q(idle_stop_q),
    .pri_q(pri_q), .sec_q(sec_q)
  );

  always_comb begin
    refs[REF_PRI]  = pri_q;
    refs[REF_SEC]  = sec_q;
    refs[REF_DUTY] = duty_q;
    run            = ~(idle_stop_q & idle);
  end

  ocmp_match #(.CNT_W(CNT_W)) u_match (
    .clk(clk), .rst_n(rst_int_n), .tsel(tsel_q),
    .cnt0(tmr0_cnt), .wrap0(tmr0_wrap), .cnt1(tmr1_cnt), .wrap1(tmr1_wrap),
    .refs(refs), .ev(ev), .roll(roll)
  );

  ocmp_engine #(.CNT_W(CNT_W)) u_engine (
    .clk(clk), .rst_n(rst_int_n), .mode(mode_q), .run(run),
    .init(ctl_wr), .init_mode(oc_mode_e'(ctl_mode)),
    .ev_pri(ev[REF_PRI]), .ev_sec(ev[REF_SEC]), .ev_duty(ev[REF_DUTY]),
    .roll(roll), .fault(fault), .sec_val(sec_q),
    .pin_q(oc_out), .flag_q(fault_flag), .duty_q(duty_q)
  );
endmodule

// File: rtl/ocmp_channel_chk.sv
module ocmp_channel_chk (
  input logic       clk,
  input logic       rst_int_n,
  input logic       ctl_wr,
  input logic [2:0] ctl_mode,
  input logic [2:0] mode_q,
  input logic       idle_stop_q,
  input logic       idle,
  input logic       fault,
  input logic       oc_out,
  input logic       fault_flag
);
  p_off_low_r1: assert property (@(posedge clk) disable iff (!rst_int_n)
    (mode_q == 3'd0 && !ctl_wr) |=> !oc_out);

  p_init_low_r2: assert property (@(posedge clk) disable iff (!rst_int_n)
    (ctl_wr && ctl_mode != 3'd2) |=> !oc_out);

  p_init_high_r3: assert property (@(posedge clk) disable iff (!rst_int_n)
    (ctl_wr && ctl_mode == 3'd2) |=> oc_out);

  p_fault_trip_r8: assert property (@(posedge clk) disable iff (!rst_int_n)
    (mode_q == 3'd7 && fault && !ctl_wr) |=> (fault_flag && !oc_out));

  p_flag_source_r8: assert property (@(posedge clk) disable iff (!rst_int_n)
    $rose(fault_flag) |-> $past(mode_q == 3'd7 && fault));

  p_flag_sticky_r9: assert property (@(posedge clk) disable iff (!rst_int_n)
    (fault_flag && !ctl_wr) |=> fault_flag);

  p_flag_clear_r9: assert property (@(posedge clk) disable iff (!rst_int_n)
    ctl_wr |=> !fault_flag);

  p_flag_pin_low_r9: assert property (@(posedge clk) disable iff (!rst_int_n)
    fault_flag |-> !oc_out);

  p_halt_hold_r11: assert property (@(posedge clk) disable iff (!rst_int_n)
    (idle_stop_q && idle && !ctl_wr && mode_q != 3'd7) |=> $stable(oc_out));
endmodule

bind ocmp_channel ocmp_channel_chk u_chk (
  .clk(clk), .rst_int_n(rst_int_n), .ctl_wr(ctl_wr), .ctl_mode(ctl_mode),
  .mode_q(mode_q), .idle_stop_q(idle_stop_q), .idle(idle), .fault(fault),
  .oc_out(oc_out), .fault_flag(fault_flag)
);

// File: tb/ocmp_channel_bench.sv
`timescale 1ns/1ps
module ocmp_channel_bench;
  localparam int W  = 16;
  localparam int PA = 16;
  localparam int PB = 10;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         ctl_wr = 1'b0;
  logic [2:0]   ctl_mode = 3'd0;
  logic         ctl_tsel = 1'b0;
  logic         ctl_idle_stop = 1'b0;
  logic         pri_wr = 1'b0;
  logic [W-1:0] pri_wdata = '0;
  logic         sec_wr = 1'b0;
  logic [W-1:0] sec_wdata = '0;
  logic [W-1:0] a_cnt = '0;
  logic         a_wrap = 1'b0;
  logic [W-1:0] b_cnt = '0;
  logic         b_wrap = 1'b0;
  logic         idle = 1'b0;
  logic         fault = 1'b0;
  logic         oc_out;
  logic         fault_flag;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  ocmp_channel #(.CNT_W(W)) u_ocmp_channel (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_mode(ctl_mode),
    .ctl_tsel(ctl_tsel), .ctl_idle_stop(ctl_idle_stop),
    .pri_wr(pri_wr), .pri_wdata(pri_wdata), .sec_wr(sec_wr), .sec_wdata(sec_wdata),
    .tmr0_cnt(a_cnt), .tmr0_wrap(a_wrap), .tmr1_cnt(b_cnt), .tmr1_wrap(b_wrap),
    .idle(idle), .fault(fault), .oc_out(oc_out), .fault_flag(fault_flag)
  );

  initial begin
    forever begin
      @(posedge clk);
      #1;
      a_cnt  = (a_cnt == W'(PA-1)) ? '0 : a_cnt + 1'b1;
      a_wrap = (a_cnt == W'(PA-1));
      b_cnt  = (b_cnt == W'(PB-1)) ? '0 : b_cnt + 1'b1;
      b_wrap = (b_cnt == W'(PB-1));
    end
  end

  task automatic chk(input string tag, input logic act, input logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b (t=%0t, cntA=%0d cntB=%0d)",
               tag, act, exp, $time, a_cnt, b_cnt);
    end
  endtask

  task automatic wait_a(input int c);
    do @(negedge clk); while (a_cnt != W'(c));
  endtask

  task automatic wait_b(input int c);
    do @(negedge clk); while (b_cnt != W'(c));
  endtask

  task automatic wr_ctl(input logic [2:0] m, input logic t, input logic s);
    @(posedge clk); #2;
    ctl_wr = 1'b1; ctl_mode = m; ctl_tsel = t; ctl_idle_stop = s;
    @(posedge clk); #2;
    ctl_wr = 1'b0;
  endtask

  task automatic wr_pri(input int v);
    @(posedge clk); #2;
    pri_wr = 1'b1; pri_wdata = W'(v);
    @(posedge clk); #2;
    pri_wr = 1'b0;
  endtask

  task automatic wr_sec(input int v);
    @(posedge clk); #2;
    sec_wr = 1'b1; sec_wdata = W'(v);
    @(posedge clk); #2;
    sec_wr = 1'b0;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  task automatic pulse_pair(input logic [2:0] m, input int p, input int s);
    wr_ctl(3'd0, 1'b0, 1'b0);
    wr_pri(p);
    wr_sec(s);
    wait_a((p + 8) % PA);
    wr_ctl(m, 1'b0, 1'b0);
    wait_a(p);            chk("R5 before rise", oc_out, 1'b0);
    wait_a((p + 1) % PA); chk("R5 rise", oc_out, 1'b1);
    wait_a(s);            chk("R5 held high", oc_out, 1'b1);
    wait_a((s + 1) % PA); chk("R5 fall", oc_out, 1'b0);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    #2 rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state and disabled mode
    chk("R1 reset pin", oc_out, 1'b0);
    chk("R1 reset flag", fault_flag, 1'b0);
    wr_pri(3);
    for (int i = 0; i < PA + 2; i++) begin
      @(negedge clk);
      chk("R1 off low", oc_out, 1'b0);
    end

    // R2 and R3: every primary compare value over one timer 0 period
    for (int r = 0; r < PA; r++) begin
      wr_ctl(3'd0, 1'b0, 1'b0);
      wr_pri(r);
      wait_a((r + 8) % PA);
      wr_ctl(3'd1, 1'b0, 1'b0);
      wait_a(r);            chk("R2 before match", oc_out, 1'b0);
      wait_a((r + 1) % PA); chk("R2 after match", oc_out, 1'b1);
      wait_a((r + 1) % PA); chk("R2 stays high", oc_out, 1'b1);
    end
    for (int r = 0; r < PA; r++) begin
      wr_ctl(3'd0, 1'b0, 1'b0);
      wr_pri(r);
      wait_a((r + 8) % PA);
      wr_ctl(3'd2, 1'b0, 1'b0);
      wait_a(r);            chk("R3 before match", oc_out, 1'b1);
      wait_a((r + 1) % PA); chk("R3 after match", oc_out, 1'b0);
    end

    // R4: toggle on each match
    wr_ctl(3'd0, 1'b0, 1'b0);
    wr_pri(5);
    wait_a(12);
    wr_ctl(3'd3, 1'b0, 1'b0);
    wait_a(4); chk("R4 initial low", oc_out, 1'b0);
    for (int k = 0; k < 4; k++) begin
      wait_a(6);
      chk("R4 toggle", oc_out, (k % 2) == 0);
    end

    // R5: single pulse, then silence for two periods
    pulse_pair(3'd4, 3, 9);
    for (int i = 0; i < 2 * PA; i++) begin
      @(negedge clk); chk("R5 no second pulse", oc_out, 1'b0);
    end
    pulse_pair(3'd4, 12, 4);
    for (int i = 0; i < 2 * PA; i++) begin
      @(negedge clk); chk("R5 no second pulse", oc_out, 1'b0);
    end
    wr_ctl(3'd0, 1'b0, 1'b0);
    wr_pri(5);
    wr_sec(5);
    wait_a(13);
    wr_ctl(3'd4, 1'b0, 1'b0);
    wait_a(5); chk("R5 equal before", oc_out, 1'b0);
    wait_a(6); chk("R5 equal rise", oc_out, 1'b1);
    wait_a(5); chk("R5 equal held", oc_out, 1'b1);
    wait_a(6); chk("R5 equal fall", oc_out, 1'b0);

    // R6: continuous pulses, high for counts 3..11
    wr_ctl(3'd0, 1'b0, 1'b0);
    wr_pri(2);
    wr_sec(11);
    wait_a(10);
    wr_ctl(3'd5, 1'b0, 1'b0);
    wait_a(3);
    for (int i = 0; i < 3 * PA; i++) begin
      chk("R6 continuous", oc_out, (a_cnt >= 3) && (a_cnt <= 11));
      @(negedge clk);
    end

    // R7: PWM sweep of every duty value, fault toggled but ignored
    wr_ctl(3'd0, 1'b0, 1'b0);
    wait_a(8);
    wr_ctl(3'd6, 1'b0, 1'b0);
    for (int d = 0; d <= PA; d++) begin
      fault = d[0];
      wr_sec(d);
      wait_a(PA - 1);
      wait_a(0);
      for (int i = 0; i < PA; i++) begin
        chk("R7 pwm duty", oc_out, (d != 0) && (int'(a_cnt) <= d));
        if (i < PA - 1) @(negedge clk);
      end
      chk("R7 flag stays low", fault_flag, 1'b0);
    end
    fault = 1'b0;

    // R10: PWM on timer 1
    wr_ctl(3'd0, 1'b0, 1'b0);
    wait_a(8);
    wr_ctl(3'd6, 1'b1, 1'b0);
    for (int j = 0; j < 2; j++) begin
      int d;
      d = (j == 0) ? 3 : 7;
      wr_sec(d);
      wait_b(PB - 1);
      wait_b(0);
      for (int i = 0; i < PB; i++) begin
        chk("R10 timer1 pwm", oc_out, int'(b_cnt) <= d);
        if (i < PB - 1) @(negedge clk);
      end
    end

    // R8 and R9: fault trip, persistence, restart by control write
    wr_ctl(3'd0, 1'b0, 1'b0);
    wr_sec(8);
    wait_a(8);
    wr_ctl(3'd7, 1'b0, 1'b0);
    wait_a(0);
    wait_a(3);
    chk("R8 running before fault", oc_out, 1'b1);
    fault = 1'b1;
    wait_a(4);
    chk("R8 pin forced low", oc_out, 1'b0);
    chk("R8 flag set", fault_flag, 1'b1);
    fault = 1'b0;
    for (int i = 0; i < 2 * PA; i++) begin
      @(negedge clk);
      chk("R9 pin stays low", oc_out, 1'b0);
      chk("R9 flag stays set", fault_flag, 1'b1);
    end
    wr_sec(2);
    @(negedge clk);
    chk("R9 sec write keeps flag", fault_flag, 1'b1);
    wait_a(8);
    wr_ctl(3'd7, 1'b0, 1'b0);
    chk("R9 control write clears flag", fault_flag, 1'b0);
    wait_a(0);
    chk("R9 pwm resumes", oc_out, 1'b1);
    wait_a(3);
    chk("R9 new duty", oc_out, 1'b0);

    // R11: idle stop
    wr_ctl(3'd0, 1'b0, 1'b0);
    wr_pri(5);
    wait_a(12);
    wr_ctl(3'd3, 1'b0, 1'b1);
    idle = 1'b1;
    wait_a(7);
    chk("R11 halted in idle", oc_out, 1'b0);
    idle = 1'b0;
    wait_a(7);
    chk("R11 resumes after idle", oc_out, 1'b1);
    wait_a(12);
    wr_ctl(3'd3, 1'b0, 1'b0);
    idle = 1'b1;
    wait_a(7);
    chk("R11 runs when stop bit clear", oc_out, 1'b1);
    idle = 1'b0;

    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end
endmodule